// File: doc/BRIEF.md
# Exception Entry Dispatch Controller

This block settles how a processor core enters a handler once an exception or an external interrupt is pending. When the core pulses the take strobe, the block weighs the pending exception code against the interrupt request. It applies the blocked-mode rules from the status word and works out a single entry event. For that event it produces the values the core must commit: the saved status, the saved return address and the saved stack register, the event code register to update, the new status word and the handler address.

All results are registered. They appear one cycle after the strobe, together with a one-cycle taken pulse and write enables. The outputs keep their last values until the next event is taken. The block also drives the current interrupt mask to the interrupt controller. In return it receives the vector that the controller considers eligible, together with a valid flag.

Top module: `evt_entry_ctrl`

## Requirements
- R1: When `exc_valid_i` and `irq_req_i` are both high at a take, the exception is taken: `expevt_we_o` pulses and `intevt_we_o` stays low.
- R2: When status bit 28 (block) is set, a pending exception with any code other than 0x1E0 is recorded and dispatched as code 0x000. Code 0x1E0 is kept unchanged.
- R3: When status bit 28 is set and no exception is pending, an interrupt request is ignored unless `sleep_i` is high. An ignored request leaves every output register unchanged and gives no taken pulse.
- R4: `irq_mask_o` always equals status bits 7:4. An interrupt with `irq_vec_valid_i` low is not taken.
- R5: On every taken event, `ssr_o` holds the old status, `sgr_o` holds `r15_i`, and `new_sr_o` is the old status with bits 28, 29 and 30 set.
- R6: With `dslot_i` high, the saved return address is `pc_i` minus 2 and `clr_dslot_o` pulses with the taken pulse. Otherwise the return address is `pc_i` and `clr_dslot_o` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, set status bits 7:4 to 0xF and jump to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 jump to `vbr_i`+0x400. Every other exception code not listed in R7 jumps to `vbr_i`+0x100.
- R9: The trap code 0x160 adds 2 to the saved return address, after any delay-slot rewind.
- R10: A taken interrupt writes the vector into `intevt_o`, pulses `intevt_we_o` and jumps to `vbr_i`+0x600. A taken exception writes its final code into `expevt_o`.
- R11: All results appear in the cycle after `take_i`. `taken_o` and `clr_sleep_o` pulse together. Nothing is taken while `take_i` is low, or when a take finds nothing eligible.
- R12: After reset, every output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Single-cycle request to dispatch the pending event |
| exc_valid_i | input | 1 | An exception code is pending |
| exc_code_i | input | CODE_W | Pending exception code |
| irq_req_i | input | 1 | External interrupt request |
| irq_vec_valid_i | input | 1 | Interrupt controller has an eligible vector |
| irq_vec_i | input | CODE_W | Eligible interrupt vector |
| irq_mask_o | output | 4 | Current interrupt mask (status bits 7:4) |
| sr_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Address of the faulting or next instruction |
| r15_i | input | XLEN | General register 15 |
| vbr_i | input | XLEN | Vector base |
| sleep_i | input | 1 | Core is sleeping |
| dslot_i | input | 1 | Event hits a delay-slot instruction |
| taken_o | output | 1 | One-cycle pulse, an event was taken |
| ssr_o | output | XLEN | Saved status |
| spc_o | output | XLEN | Saved return address |
| sgr_o | output | XLEN | Saved register 15 |
| new_sr_o | output | XLEN | Status word for the handler |
| new_pc_o | output | XLEN | Handler address |
| expevt_we_o | output | 1 | Exception event register write |
| expevt_o | output | CODE_W | Exception event code |
| intevt_we_o | output | 1 | Interrupt event register write |
| intevt_o | output | CODE_W | Interrupt event vector |
| clr_sleep_o | output | 1 | Clear the sleep flag |
| clr_dslot_o | output | 1 | Clear the delay-slot flags |

## Verification
Two functions can meet in one take: the exception/interrupt priority and the blocked-mode filter. The bench raises an exception and an interrupt in the same cycle, with the block bit both clear and set. It judges the result by which event register is written and by the final code. A second meeting point is the delay-slot rewind together with the trap adjustment, which must cancel to the original address. A behavioural reference model predicts every output on every clock, and the bench compares the design against it.

// File: rtl/evt_pkg.sv
package evt_pkg;
  // Status word bit positions the dispatch depends on
  localparam int unsigned SR_BLOCK = 28;
  localparam int unsigned SR_BANK  = 29;
  localparam int unsigned SR_PRIV  = 30;
  localparam int unsigned SR_FPDIS = 15;
  localparam int unsigned SR_MLO   = 4;
  localparam int unsigned SR_MHI   = 7;

  // Event codes with special handling
  localparam logic [11:0] C_RESET    = 12'h000;
  localparam logic [11:0] C_MRESET   = 12'h020;
  localparam logic [11:0] C_MULTIHIT = 12'h140;
  localparam logic [11:0] C_RDMISS   = 12'h040;
  localparam logic [11:0] C_WRMISS   = 12'h060;
  localparam logic [11:0] C_TRAP     = 12'h160;
  localparam logic [11:0] C_KEEPBL   = 12'h1E0;

  // Handler address offsets
  localparam logic [31:0] RESET_PC = 32'hA000_0000;
  localparam logic [31:0] OFS_GEN  = 32'h0000_0100;
  localparam logic [31:0] OFS_MISS = 32'h0000_0400;
  localparam logic [31:0] OFS_IRQ  = 32'h0000_0600;

  typedef enum logic [1:0] {
    EK_NONE = 2'd0,
    EK_EXC  = 2'd1,
    EK_IRQ  = 2'd2
  } evt_kind_e;
endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_pkg::*;
#(
  parameter int unsigned CODE_W = 12
) (
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic              blocked_i,
  input  logic              sleep_i,
  output evt_kind_e         kind_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] KEEP = CODE_W'(C_KEEPBL);
  localparam logic [CODE_W-1:0] RST  = CODE_W'(C_RESET);

  logic irq_allowed;

  // Exceptions win; interrupts in blocked mode only wake a sleeping core
  assign irq_allowed = irq_req_i && irq_vec_valid_i && (!blocked_i || sleep_i);

  always_comb begin
    kind_o = EK_NONE;
    code_o = exc_code_i;
    if (exc_valid_i) begin
      kind_o = EK_EXC;
      if (blocked_i && (exc_code_i != KEEP)) begin
        code_o = RST;
      end
    end else if (irq_allowed) begin
      kind_o = EK_IRQ;
    end
  end
endmodule

// File: rtl/evt_target.sv
module evt_target
  import evt_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 12
) (
  input  evt_kind_e         kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [XLEN-1:0]   new_sr_o,
  output logic [XLEN-1:0]   ret_pc_o
);
  localparam int unsigned MASK_W = SR_MHI - SR_MLO + 1;

  logic rst_class;
  logic miss_class;
  logic is_trap;

  assign rst_class  = (kind_i == EK_EXC) &&
                      ((code_i == CODE_W'(C_RESET)) ||
                       (code_i == CODE_W'(C_MRESET)) ||
                       (code_i == CODE_W'(C_MULTIHIT)));
  assign miss_class = (kind_i == EK_EXC) &&
                      ((code_i == CODE_W'(C_RDMISS)) ||
                       (code_i == CODE_W'(C_WRMISS)));
  assign is_trap    = (kind_i == EK_EXC) && (code_i == CODE_W'(C_TRAP));

  // Return address: delay-slot rewind, then trap step
  always_comb begin
    ret_pc_o = pc_i;
    if (dslot_i) begin
      ret_pc_o = ret_pc_o - XLEN'(2);
    end
    if (is_trap) begin
      ret_pc_o = ret_pc_o + XLEN'(2);
    end
  end

  // Handler status word
  always_comb begin
    new_sr_o = sr_i;
    new_sr_o[SR_BLOCK] = 1'b1;
    new_sr_o[SR_BANK]  = 1'b1;
    new_sr_o[SR_PRIV]  = 1'b1;
    if (rst_class) begin
      new_sr_o[SR_FPDIS]       = 1'b0;
      new_sr_o[SR_MHI:SR_MLO]  = {MASK_W{1'b1}};
    end
  end

  // Handler address
  always_comb begin
    if (kind_i == EK_IRQ) begin
      new_pc_o = vbr_i + XLEN'(OFS_IRQ);
    end else if (rst_class) begin
      new_pc_o = XLEN'(RESET_PC);
    end else if (miss_class) begin
      new_pc_o = vbr_i + XLEN'(OFS_MISS);
    end else begin
      new_pc_o = vbr_i + XLEN'(OFS_GEN);
    end
  end
endmodule

// File: rtl/evt_entry_ctrl.sv
module evt_entry_ctrl
  import evt_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  output logic [3:0]        irq_mask_o,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              sleep_i,
  input  logic              dslot_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [XLEN-1:0]   new_sr_o,
  output logic [XLEN-1:0]   new_pc_o,
  output logic              expevt_we_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic              intevt_we_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic              clr_sleep_o,
  output logic              clr_dslot_o
);
  evt_kind_e         kind;
  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   tgt_pc, tgt_sr, ret_pc;
  logic              go;

  // Next-state signals
  logic              taken_d, ew_d, iw_d, cs_d, cd_d;
  logic [XLEN-1:0]   ssr_d, spc_d, sgr_d, nsr_d, npc_d;
  logic [CODE_W-1:0] exp_d, int_d;

  assign irq_mask_o = sr_i[SR_MHI:SR_MLO];

  evt_arbiter #(.CODE_W(CODE_W)) u_arb (
    .exc_valid_i     (exc_valid_i),
    .exc_code_i      (exc_code_i),
    .irq_req_i       (irq_req_i),
    .irq_vec_valid_i (irq_vec_valid_i),
    .blocked_i       (sr_i[SR_BLOCK]),
    .sleep_i         (sleep_i),
    .kind_o          (kind),
    .code_o          (eff_code)
  );

  evt_target #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tgt (
    .kind_i   (kind),
    .code_i   (eff_code),
    .sr_i     (sr_i),
    .pc_i     (pc_i),
    .vbr_i    (vbr_i),
    .dslot_i  (dslot_i),
    .new_pc_o (tgt_pc),
    .new_sr_o (tgt_sr),
    .ret_pc_o (ret_pc)
  );

  assign go = take_i && (kind != EK_NONE);

  always_comb begin
    taken_d = go;
    ew_d    = go && (kind == EK_EXC);
    iw_d    = go && (kind == EK_IRQ);
    cs_d    = go;
    cd_d    = go && dslot_i;
    ssr_d   = ssr_o;
    spc_d   = spc_o;
    sgr_d   = sgr_o;
    nsr_d   = new_sr_o;
    npc_d   = new_pc_o;
    exp_d   = expevt_o;
    int_d   = intevt_o;
    if (go) begin
      ssr_d = sr_i;
      spc_d = ret_pc;
      sgr_d = r15_i;
      nsr_d = tgt_sr;
      npc_d = tgt_pc;
      if (kind == EK_EXC) begin
        exp_d = eff_code;
      end else begin
        int_d = irq_vec_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o     <= 1'b0;
      expevt_we_o <= 1'b0;
      intevt_we_o <= 1'b0;
      clr_sleep_o <= 1'b0;
      clr_dslot_o <= 1'b0;
      ssr_o       <= '0;
      spc_o       <= '0;
      sgr_o       <= '0;
      new_sr_o    <= '0;
      new_pc_o    <= '0;
      expevt_o    <= '0;
      intevt_o    <= '0;
    end else begin
      taken_o     <= taken_d;
      expevt_we_o <= ew_d;
      intevt_we_o <= iw_d;
      clr_sleep_o <= cs_d;
      clr_dslot_o <= cd_d;
      ssr_o       <= ssr_d;
      spc_o       <= spc_d;
      sgr_o       <= sgr_d;
      new_sr_o    <= nsr_d;
      new_pc_o    <= npc_d;
      expevt_o    <= exp_d;
      intevt_o    <= int_d;
    end
  end

  // R1
  one_event_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({expevt_we_o, intevt_we_o}));

  // R11
  taken_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $past(take_i));

  // R11
  taken_has_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> ((expevt_we_o || intevt_we_o) && clr_sleep_o));

  // R5
  entry_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (new_sr_o[SR_BLOCK] && new_sr_o[SR_BANK] && new_sr_o[SR_PRIV]));

  // R2
  blocked_exc_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && exc_valid_i && sr_i[SR_BLOCK] && (exc_code_i != CODE_W'(C_KEEPBL)))
      |=> (expevt_we_o && (expevt_o == CODE_W'(C_RESET))));

  // R3
  blocked_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !exc_valid_i && sr_i[SR_BLOCK] && !sleep_i) |=> !taken_o);

  // R7
  reset_class_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expevt_we_o && (expevt_o == CODE_W'(C_RESET)))
      |-> ((new_pc_o == XLEN'(RESET_PC)) && (new_sr_o[SR_MHI:SR_MLO] == 4'hF)));
endmodule

// File: tb/sim_evt_entry_ctrl.sv
`timescale 1ns/1ps
module sim_evt_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        take_i, exc_valid_i, irq_req_i, irq_vec_valid_i, sleep_i, dslot_i;
  logic [11:0] exc_code_i, irq_vec_i;
  logic [31:0] sr_i, pc_i, r15_i, vbr_i;
  logic [3:0]  irq_mask_o;
  logic        taken_o, expevt_we_o, intevt_we_o, clr_sleep_o, clr_dslot_o;
  logic [31:0] ssr_o, spc_o, sgr_o, new_sr_o, new_pc_o;
  logic [11:0] expevt_o, intevt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit live = 0;

  always #10 clk = ~clk;

  evt_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .exc_valid_i(exc_valid_i),
    .exc_code_i(exc_code_i), .irq_req_i(irq_req_i), .irq_vec_valid_i(irq_vec_valid_i),
    .irq_vec_i(irq_vec_i), .irq_mask_o(irq_mask_o), .sr_i(sr_i), .pc_i(pc_i),
    .r15_i(r15_i), .vbr_i(vbr_i), .sleep_i(sleep_i), .dslot_i(dslot_i),
    .taken_o(taken_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o),
    .new_sr_o(new_sr_o), .new_pc_o(new_pc_o), .expevt_we_o(expevt_we_o),
    .expevt_o(expevt_o), .intevt_we_o(intevt_we_o), .intevt_o(intevt_o),
    .clr_sleep_o(clr_sleep_o), .clr_dslot_o(clr_dslot_o)
  );

  // Behavioural reference model
  logic        m_taken, m_ew, m_iw, m_cs, m_cd;
  logic [31:0] m_ssr, m_spc, m_sgr, m_sr, m_pc;
  logic [11:0] m_exp, m_int;
  int          sel;
  logic [11:0] mcode;
  logic [31:0] mret;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_taken, m_ew, m_iw, m_cs, m_cd} = '0;
      {m_ssr, m_spc, m_sgr, m_sr, m_pc} = '0;
      m_exp = '0; m_int = '0;
    end else begin
      {m_taken, m_ew, m_iw, m_cs, m_cd} = '0;
      sel = 0;
      mcode = exc_code_i;
      if (take_i) begin
        if (exc_valid_i) begin
          sel = 1;
          if (sr_i[28] && mcode != 12'h1E0) mcode = 12'h000;
        end else if (irq_req_i && irq_vec_valid_i && (!sr_i[28] || sleep_i)) begin
          sel = 2;
        end
      end
      if (sel != 0) begin
        m_taken = 1; m_cs = 1; m_cd = dslot_i;
        m_ssr = sr_i; m_sgr = r15_i;
        m_sr = sr_i | 32'h7000_0000;
        mret = dslot_i ? pc_i - 32'd2 : pc_i;
        if (sel == 1) begin
          m_ew = 1; m_exp = mcode;
          case (mcode)
            12'h000, 12'h020, 12'h140: begin
              m_sr[15] = 1'b0; m_sr[7:4] = 4'hF; m_pc = 32'hA000_0000;
            end
            12'h040, 12'h060: m_pc = vbr_i + 32'h400;
            12'h160: begin mret = mret + 32'd2; m_pc = vbr_i + 32'h100; end
            default: m_pc = vbr_i + 32'h100;
          endcase
        end else begin
          m_iw = 1; m_int = irq_vec_i; m_pc = vbr_i + 32'h600;
        end
        m_spc = mret;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R11", "taken", 32'(taken_o), 32'(m_taken));
      chk("R11", "clr_sleep", 32'(clr_sleep_o), 32'(m_cs));
      chk("R1", "expevt_we", 32'(expevt_we_o), 32'(m_ew));
      chk("R10", "intevt_we", 32'(intevt_we_o), 32'(m_iw));
      chk("R2", "expevt", 32'(expevt_o), 32'(m_exp));
      chk("R10", "intevt", 32'(intevt_o), 32'(m_int));
      chk("R5", "ssr", ssr_o, m_ssr);
      chk("R5", "sgr", sgr_o, m_sgr);
      chk("R7", "new_sr", new_sr_o, m_sr);
      chk("R8", "new_pc", new_pc_o, m_pc);
      chk("R9", "spc", spc_o, m_spc);
      chk("R6", "clr_dslot", 32'(clr_dslot_o), 32'(m_cd));
      chk("R4", "irq_mask", 32'(irq_mask_o), 32'(sr_i[7:4]));
    end
  end

  task automatic idle_inputs();
    take_i = 0; exc_valid_i = 0; irq_req_i = 0; irq_vec_valid_i = 0;
    sleep_i = 0; dslot_i = 0; exc_code_i = 12'hFFF; irq_vec_i = 12'h000;
  endtask

  // Drive one event 5 ns after a rising edge, then idle one cycle
  task automatic fire(input logic tk, input logic ev, input logic [11:0] code,
                      input logic irq, input logic vv, input logic [11:0] vec,
                      input logic [31:0] sr, input logic slp, input logic ds);
    @(posedge clk); #5;
    take_i = tk; exc_valid_i = ev; exc_code_i = code; irq_req_i = irq;
    irq_vec_valid_i = vv; irq_vec_i = vec; sr_i = sr; sleep_i = slp; dslot_i = ds;
    pc_i = pc_i + 32'h40; r15_i = r15_i + 32'h11;
    @(posedge clk); #5;
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    sr_i = 32'h4000_00F0; pc_i = 32'h8C00_1000; r15_i = 32'h8C0F_FF00;
    vbr_i = 32'h8C00_0000;
    repeat (3) @(posedge clk);
    #5;
    // R12: reset state
    chk("R12", "taken", 32'(taken_o), 32'd0);
    chk("R12", "new_pc", new_pc_o, 32'd0);
    chk("R12", "spc", spc_o, 32'd0);
    chk("R12", "expevt", 32'(expevt_o), 32'd0);
    rst_n = 1;
    live = 1;
    // R8: general exception and miss class
    fire(1, 1, 12'h0E0, 0, 0, 12'h0, 32'h4000_0030, 0, 0);
    fire(1, 1, 12'h040, 0, 0, 12'h0, 32'h4000_0030, 0, 0);
    fire(1, 1, 12'h060, 0, 0, 12'h0, 32'h4000_0030, 0, 0);
    // R7: reset class, FD set beforehand
    fire(1, 1, 12'h020, 0, 0, 12'h0, 32'h4000_8030, 0, 0);
    fire(1, 1, 12'h140, 0, 0, 12'h0, 32'h4000_8050, 0, 0);
    // R9: trap, and trap in delay slot
    fire(1, 1, 12'h160, 0, 0, 12'h0, 32'h4000_0000, 0, 0);
    fire(1, 1, 12'h160, 0, 0, 12'h0, 32'h4000_0000, 0, 1);
    // R6: delay-slot rewind
    fire(1, 1, 12'h180, 0, 0, 12'h0, 32'h4000_0000, 0, 1);
    // R10: interrupt
    fire(1, 0, 12'hFFF, 1, 1, 12'h320, 32'h0000_0070, 0, 0);
    // R1: exception and interrupt together
    fire(1, 1, 12'h100, 1, 1, 12'h340, 32'h0000_0000, 0, 0);
    // R2: blocked exceptions
    fire(1, 1, 12'h0E0, 0, 0, 12'h0, 32'h5000_8000, 0, 0);
    fire(1, 1, 12'h1E0, 0, 0, 12'h0, 32'h5000_0000, 0, 0);
    fire(1, 1, 12'h0A0, 1, 1, 12'h360, 32'h1000_0000, 1, 0);
    // R3: blocked interrupt, awake then sleeping
    fire(1, 0, 12'hFFF, 1, 1, 12'h380, 32'h1000_0000, 0, 0);
    fire(1, 0, 12'hFFF, 1, 1, 12'h3A0, 32'h1000_0000, 1, 0);
    // R4: no eligible vector
    fire(1, 0, 12'hFFF, 1, 0, 12'h3C0, 32'h0000_00A0, 0, 0);
    // R11: no take, and take with nothing pending
    fire(0, 1, 12'h0E0, 1, 1, 12'h3E0, 32'h0000_0000, 0, 0);
    fire(1, 0, 12'hFFF, 0, 0, 12'h0, 32'h0000_0000, 0, 1);
    // R11: back-to-back takes
    @(posedge clk); #5;
    take_i = 1; exc_valid_i = 1; exc_code_i = 12'h1A0; sr_i = 32'h4000_0000;
    @(posedge clk); #5;
    exc_valid_i = 0; irq_req_i = 1; irq_vec_valid_i = 1; irq_vec_i = 12'h400;
    vbr_i = 32'h8800_0000;
    @(posedge clk); #5;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    live = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule